// File: doc/BRIEF.md
# Board Control Register Block

This block is a 32-bit bus slave that holds the small set of control registers an evaluation board's support logic offers to its processor. It has an eight-LED bar, an eight-character text display buffer, a keyed software reset trigger, a break/reset byte and a general-purpose output byte. It also holds a group of registers through which software drives a two-wire serial bus by toggling its clock and data lines directly.

Only the low 20 bits of the bus address take part in decoding. A write to the word-display register turns its 32-bit data into eight uppercase hexadecimal ASCII characters. Each of the eight per-character registers replaces one character. The reset request leaves the block as a registered one-cycle pulse. Read data is registered and appears one cycle after the read strobe.

Top module: `brd_ctl_regs`

## Requirements
- R1: Decoding uses only address bits [19:0]. A read of an offset with no register returns 0. A write to such an offset changes no register, output or display character. This includes 0x404, 0x41C, 0x458 and 0x900.
- R2: The LED register at offset 0x408 stores bits [7:0] of a write. It drives `led_bar` from the cycle after the write and reads back zero-extended.
- R3: A write to offset 0x410 sets all eight display characters from the data. Character i (bits [8i+7:8i] of `disp_chars`) takes the nibble at data bits [31-4i:28-4i]. Nibble values 0-9 map to 0x30-0x39 and values 10-15 map to 0x41-0x46. The offset reads as 0.
- R4: A write to offset 0x418 + 8*i, for i from 0 to 7, sets character i to data bits [7:0]. The other characters keep their values. These offsets read as 0.
- R5: A write of exactly 0x00000042 to offset 0x500 raises `sys_reset_req` for exactly the one cycle after the write. Any other data value, or the key written to any other offset, leaves it low.
- R6: The break/reset register at 0x508 and the general-purpose output register at 0xA00 each store data bits [7:0] and read back zero-extended.
- R7: Offsets 0x200 and 0x210 read as 0. Offset 0x208 reads 0x12 when the parameter BIG_ENDIAN is 1 and 0x10 when it is 0.
- R8: The output-enable register at 0xB08 stores bits [1:0]. The select register at 0xB18 stores bit 0. The output register at 0xB10 stores all 32 bits, drives `twi_scl_o` from bit 1 and `twi_sda_o` from bit 0, and reads back in full.
- R9: Offset 0xB00 reads 0x2 with bit 0 replaced by the live `twi_sda_i` level.
- R10: Offset 0xA08 reads the output register at 0xB10 when select is 1, and reads 0 when select is 0.
- R11: After reset the registers hold these values: LED 0x00, break 0x0A, general output 0x00, output enable 0x0, output register 0x3, select 0x1, every display character 0x20, and `sys_reset_req` low.
- R12: `bus_rdata` shows the read result in the cycle after `bus_re` is high. It is 0 in the cycle after a cycle with `bus_re` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Bus address; bits [19:0] are decoded |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| led_bar | output | 8 | LED bar levels |
| disp_chars | output | 64 | Eight display characters, character 0 in bits [7:0] |
| twi_scl_o | output | 1 | Two-wire clock output level |
| twi_sda_o | output | 1 | Two-wire data output level |
| twi_sda_i | input | 1 | Live two-wire data input |

## Verification
The bench sweeps every nibble value through the word-display register. A design with the character order reversed, or with the letter offset wrong, would show the wrong characters at positions 0 or 7, or lowercase or shifted letters for 10 to 15. Reset-key values next to the key (0x41, 0x43, 0x142, 0xFFFFFF42) and the key written to a neighbouring offset catch a compare that looks at only the low byte or misdecodes the offset. Misaligned and out-of-range character offsets are written to catch a loose stride decode that would overwrite a neighbouring character. Addresses with high bits set catch a design that masks the address incorrectly. The select-gated input register and the live data-input bit are checked with both levels, so a reversed gate or a stored copy of the input would be caught.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;

    localparam int OFFS_W = 20;
    typedef logic [OFFS_W-1:0] offs_t;

    // register offsets within the 20-bit window
    localparam offs_t OFS_SWITCH = 20'h00200;
    localparam offs_t OFS_STATUS = 20'h00208;
    localparam offs_t OFS_JUMPER = 20'h00210;
    localparam offs_t OFS_LED    = 20'h00408;
    localparam offs_t OFS_WORD   = 20'h00410;
    localparam offs_t OFS_CHAR0  = 20'h00418;
    localparam offs_t OFS_SWRST  = 20'h00500;
    localparam offs_t OFS_BRK    = 20'h00508;
    localparam offs_t OFS_GPO    = 20'h00A00;
    localparam offs_t OFS_GPIN   = 20'h00A08;
    localparam offs_t OFS_TWIN   = 20'h00B00;
    localparam offs_t OFS_TWOE   = 20'h00B08;
    localparam offs_t OFS_TWOUT  = 20'h00B10;
    localparam offs_t OFS_TWSEL  = 20'h00B18;

    localparam int CHAR_STRIDE_LOG2 = 3;

    // one flag per decoded register
    typedef struct packed {
        logic sw;
        logic status;
        logic jumper;
        logic led;
        logic word;
        logic chr;
        logic swrst;
        logic brk;
        logic gpo;
        logic gpin;
        logic twin;
        logic twoe;
        logic twout;
        logic twsel;
    } sel_t;

endpackage

// File: rtl/brd_addr_dec.sv
module brd_addr_dec
    import brd_ctl_pkg::*;
#(
    parameter int CHAR_CNT = 8,
    parameter int IDX_W    = 3
) (
    input  offs_t            offs,
    output sel_t             sel,
    output logic [IDX_W-1:0] char_idx
);

    localparam offs_t OFS_CHAR_LAST =
        OFS_CHAR0 + offs_t'((CHAR_CNT - 1) << CHAR_STRIDE_LOG2);

    offs_t char_rel;
    logic  unused_rel;

    always_comb begin
        sel      = '0;
        char_rel = offs - OFS_CHAR0;
        char_idx = char_rel[CHAR_STRIDE_LOG2 +: IDX_W];
        case (offs)
            OFS_SWITCH: sel.sw     = 1'b1;
            OFS_STATUS: sel.status = 1'b1;
            OFS_JUMPER: sel.jumper = 1'b1;
            OFS_LED:    sel.led    = 1'b1;
            OFS_WORD:   sel.word   = 1'b1;
            OFS_SWRST:  sel.swrst  = 1'b1;
            OFS_BRK:    sel.brk    = 1'b1;
            OFS_GPO:    sel.gpo    = 1'b1;
            OFS_GPIN:   sel.gpin   = 1'b1;
            OFS_TWIN:   sel.twin   = 1'b1;
            OFS_TWOE:   sel.twoe   = 1'b1;
            OFS_TWOUT:  sel.twout  = 1'b1;
            OFS_TWSEL:  sel.twsel  = 1'b1;
            default:    ;
        endcase
        // character window: aligned to the stride, inside the range
        if ((offs >= OFS_CHAR0) && (offs <= OFS_CHAR_LAST) &&
            (offs[CHAR_STRIDE_LOG2-1:0] == '0)) begin
            sel.chr = 1'b1;
        end
    end

    assign unused_rel = ^{char_rel[CHAR_STRIDE_LOG2-1:0],
                          char_rel[OFFS_W-1:CHAR_STRIDE_LOG2+IDX_W]};

endmodule

// File: rtl/brd_hex_ascii.sv
module brd_hex_ascii #(
    parameter int NIBBLES = 8
) (
    input  logic [4*NIBBLES-1:0] word_i,
    output logic [8*NIBBLES-1:0] chars_o
);

    // character g carries the g-th nibble counted from the top
    for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
        logic [3:0] nib;
        assign nib = word_i[4*(NIBBLES-1-g) +: 4];
        assign chars_o[8*g +: 8] = (nib < 4'd10) ? (8'h30 + {4'h0, nib})
                                                 : (8'h37 + {4'h0, nib});
    end

endmodule

// File: rtl/brd_disp_buf.sv
module brd_disp_buf #(
    parameter int CHAR_CNT = 8,
    parameter int IDX_W    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_we,
    input  logic [8*CHAR_CNT-1:0] word_chars,
    input  logic                  char_we,
    input  logic [IDX_W-1:0]      char_idx,
    input  logic [7:0]            char_val,
    output logic [8*CHAR_CNT-1:0] chars_o
);

    localparam logic [8*CHAR_CNT-1:0] BLANK = {CHAR_CNT{8'h20}};

    logic [8*CHAR_CNT-1:0] chars_d, chars_q;

    always_comb begin
        chars_d = chars_q;
        if (word_we) begin
            chars_d = word_chars;
        end else if (char_we) begin
            chars_d[8*char_idx +: 8] = char_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chars_q <= BLANK;
        else        chars_q <= chars_d;
    end

    assign chars_o = chars_q;

    AST_CHAR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (char_we && !word_we) |=> (chars_o[8*$past(char_idx) +: 8] == $past(char_val))) // R4
        else $error("character write not stored");

    AST_DISP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_we && !word_we) |=> $stable(chars_o)) // R1
        else $error("display changed without a display write");

endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
    import brd_ctl_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int LED_W      = 8,
    parameter int BYTE_W     = 8,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    input  logic                bus_re,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                sys_reset_req,
    output logic [LED_W-1:0]    led_bar,
    output logic [2*DATA_W-1:0] disp_chars,
    output logic                twi_scl_o,
    output logic                twi_sda_o,
    input  logic                twi_sda_i
);

    localparam int CHAR_CNT = DATA_W / 4;
    localparam int IDX_W    = (CHAR_CNT > 1) ? $clog2(CHAR_CNT) : 1;
    localparam logic [DATA_W-1:0] SWRST_KEY  = DATA_W'(32'h42);
    localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? DATA_W'(32'h12)
                                                          : DATA_W'(32'h10);
    localparam logic [DATA_W-1:0] TWIN_BASE  = DATA_W'(32'h3);
    localparam logic [DATA_W-1:0] TWOUT_RST  = DATA_W'(32'h3);
    localparam logic [BYTE_W-1:0] BRK_RST    = BYTE_W'(8'h0A);

    typedef struct packed {
        logic [LED_W-1:0]  led;
        logic [BYTE_W-1:0] brk;
        logic [BYTE_W-1:0] gpo;
        logic [1:0]        oe;
        logic [DATA_W-1:0] tout;
        logic              tsel;
        logic              rst_req;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    offs_t                 offs;
    sel_t                  sel;
    logic [$bits(sel_t)-1:0] sel_vec;
    logic                  hit;
    logic [IDX_W-1:0]      char_idx;
    logic [8*CHAR_CNT-1:0] hex_chars;
    logic                  unused_addr;

    assign offs        = bus_addr[OFFS_W-1:0];
    assign unused_addr = ^bus_addr[ADDR_W-1:OFFS_W];
    assign sel_vec     = sel;
    assign hit         = |sel_vec;

    brd_addr_dec #(
        .CHAR_CNT (CHAR_CNT),
        .IDX_W    (IDX_W)
    ) dec_i (
        .offs     (offs),
        .sel      (sel),
        .char_idx (char_idx)
    );

    brd_hex_ascii #(
        .NIBBLES (CHAR_CNT)
    ) hex_i (
        .word_i  (bus_wdata),
        .chars_o (hex_chars)
    );

    brd_disp_buf #(
        .CHAR_CNT (CHAR_CNT),
        .IDX_W    (IDX_W)
    ) disp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_we    (bus_we && sel.word),
        .word_chars (hex_chars),
        .char_we    (bus_we && sel.chr),
        .char_idx   (char_idx),
        .char_val   (bus_wdata[7:0]),
        .chars_o    (disp_chars)
    );

    always_comb begin
        regs_d         = regs_q;
        regs_d.rst_req = 1'b0;
        regs_d.rdata   = '0;

        if (bus_we) begin
            if (sel.led)   regs_d.led  = bus_wdata[LED_W-1:0];
            if (sel.brk)   regs_d.brk  = bus_wdata[BYTE_W-1:0];
            if (sel.gpo)   regs_d.gpo  = bus_wdata[BYTE_W-1:0];
            if (sel.twoe)  regs_d.oe   = bus_wdata[1:0];
            if (sel.twout) regs_d.tout = bus_wdata;
            if (sel.twsel) regs_d.tsel = bus_wdata[0];
            if (sel.swrst) regs_d.rst_req = (bus_wdata == SWRST_KEY);
        end

        // read path sees the values held before this cycle's write
        if (bus_re) begin
            if (sel.status)     regs_d.rdata = STATUS_VAL;
            else if (sel.led)   regs_d.rdata = DATA_W'(regs_q.led);
            else if (sel.brk)   regs_d.rdata = DATA_W'(regs_q.brk);
            else if (sel.gpo)   regs_d.rdata = DATA_W'(regs_q.gpo);
            else if (sel.gpin)  regs_d.rdata = regs_q.tsel ? regs_q.tout : '0;
            else if (sel.twin)  regs_d.rdata = {TWIN_BASE[DATA_W-1:1], twi_sda_i};
            else if (sel.twoe)  regs_d.rdata = DATA_W'(regs_q.oe);
            else if (sel.twout) regs_d.rdata = regs_q.tout;
            else if (sel.twsel) regs_d.rdata = DATA_W'(regs_q.tsel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.led     <= '0;
            regs_q.brk     <= BRK_RST;
            regs_q.gpo     <= '0;
            regs_q.oe      <= '0;
            regs_q.tout    <= TWOUT_RST;
            regs_q.tsel    <= 1'b1;
            regs_q.rst_req <= 1'b0;
            regs_q.rdata   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata     = regs_q.rdata;
    assign sys_reset_req = regs_q.rst_req;
    assign led_bar       = regs_q.led;
    assign twi_scl_o     = regs_q.tout[1];
    assign twi_sda_o     = regs_q.tout[0];

    AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec)) // R1
        else $error("more than one register decoded");

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !hit) |=> (bus_rdata == '0)) // R1
        else $error("undecoded read returned data");

    AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel.led) |=> (led_bar == $past(bus_wdata[LED_W-1:0]))) // R2
        else $error("LED bar not loaded");

    AST_RST_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(bus_we && sel.swrst && (bus_wdata == SWRST_KEY))) // R5
        else $error("reset request without key write");

    AST_TWO_WIRE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel.twout) |=> ((twi_scl_o == $past(bus_wdata[1])) &&
                                   (twi_sda_o == $past(bus_wdata[0])))) // R8
        else $error("two-wire pins not following output register");

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0)) // R12
        else $error("read data not cleared");

endmodule

// File: tb/brd_ctl_regs_tb_top.sv
module brd_ctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        sys_reset_req;
    logic [7:0]  led_bar;
    logic [63:0] disp_chars;
    logic        twi_scl_o;
    logic        twi_sda_o;
    logic        twi_sda_i = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    brd_ctl_regs dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_we        (bus_we),
        .bus_re        (bus_re),
        .bus_rdata     (bus_rdata),
        .sys_reset_req (sys_reset_req),
        .led_bar       (led_bar),
        .disp_chars    (disp_chars),
        .twi_scl_o     (twi_scl_o),
        .twi_sda_o     (twi_sda_o),
        .twi_sda_i     (twi_sda_i)
    );

    function automatic logic [7:0] hexc(input int n);
        return (n < 10) ? 8'(8'h30 + n) : 8'(8'h41 + n - 10);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        chk(tag, {32'h0, bus_rdata}, {32'h0, exp});
    endtask

    task automatic chk_disp(input string tag, input logic [63:0] exp);
        chk(tag, disp_chars, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] exp_d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 led", {56'h0, led_bar}, 64'h0);
        chk("R11 reset req", {63'h0, sys_reset_req}, 64'h0);
        chk("R11 pins", {62'h0, twi_scl_o, twi_sda_o}, 64'h3);
        chk_disp("R11 display blank", {8{8'h20}});
        rd_chk("R11 led reg", 32'h408, 32'h0);
        rd_chk("R11 brk", 32'h508, 32'h0A);
        rd_chk("R11 gpo", 32'hA00, 32'h0);
        rd_chk("R11 oe", 32'hB08, 32'h0);
        rd_chk("R11 out", 32'hB10, 32'h3);
        rd_chk("R11 sel", 32'hB18, 32'h1);
        // R12 idle cycle clears read data
        @(negedge clk);
        chk("R12 idle zero", {32'h0, bus_rdata}, 64'h0);

        // R7 fixed registers
        rd_chk("R7 switch", 32'h200, 32'h0);
        rd_chk("R7 status", 32'h208, 32'h12);
        rd_chk("R7 jumper", 32'h210, 32'h0);

        // R2 LED sweep
        for (int v = 0; v < 512; v += 37) begin
            wr(32'h408, 32'hFFFF_FF00 | v);
            chk("R2 led out", {56'h0, led_bar}, 64'(v & 8'hFF));
            rd_chk("R2 led read", 32'h408, 32'(v & 8'hFF));
        end

        // R1 address masking
        wr(32'hABC0_0408, 32'h1234_5677);
        chk("R1 masked write", {56'h0, led_bar}, 64'h77);
        rd_chk("R1 masked read", 32'h7FF0_0408, 32'h77);

        // R3 hex word sweep
        for (int n = 0; n < 16; n++) begin
            wr(32'h410, {8{4'(n)}});
            chk_disp("R3 uniform nibble", {8{hexc(n)}});
        end
        wr(32'h410, 32'h0123_4567);
        for (int i = 0; i < 8; i++) exp_d[8*i +: 8] = hexc(i);
        chk_disp("R3 ascending", exp_d);
        wr(32'h410, 32'h89AB_CDEF);
        for (int i = 0; i < 8; i++) exp_d[8*i +: 8] = hexc(8 + i);
        chk_disp("R3 letters", exp_d);
        rd_chk("R3 word reads zero", 32'h410, 32'h0);

        // R4 per-character writes
        for (int i = 0; i < 8; i++) begin
            wr(32'h418 + 8 * i, 32'hFFFF_FF61 + i);
            exp_d[8*i +: 8] = 8'(8'h61 + i);
            chk_disp("R4 char write", exp_d);
        end
        rd_chk("R4 char reads zero", 32'h430, 32'h0);

        // R1 undecoded offsets ignored
        wr(32'h41C, 32'h5A5A_5A5A);
        wr(32'h458, 32'h5A5A_5A5A);
        wr(32'h404, 32'h5A5A_5A5A);
        wr(32'h900, 32'h5A5A_5A5A);
        chk_disp("R1 display untouched", exp_d);
        chk("R1 led untouched", {56'h0, led_bar}, 64'h77);
        rd_chk("R1 miss read 404", 32'h404, 32'h0);
        rd_chk("R1 miss read 900", 32'h900, 32'h0);
        rd_chk("R1 miss read 41C", 32'h41C, 32'h0);

        // R5 keyed reset
        begin
            logic [31:0] near [5] = '{32'h41, 32'h43, 32'h142, 32'hFFFF_FF42, 32'h0};
            foreach (near[k]) begin
                wr(32'h500, near[k]);
                chk("R5 no pulse on wrong key", {63'h0, sys_reset_req}, 64'h0);
            end
        end
        wr(32'h508, 32'h42);
        chk("R5 no pulse on other offset", {63'h0, sys_reset_req}, 64'h0);
        wr(32'h500, 32'h42);
        chk("R5 pulse high", {63'h0, sys_reset_req}, 64'h1);
        @(negedge clk);
        chk("R5 pulse one cycle", {63'h0, sys_reset_req}, 64'h0);

        // R6 break and general output
        rd_chk("R6 brk written", 32'h508, 32'h42);
        wr(32'h508, 32'h1234_56C3);
        rd_chk("R6 brk 8 bits", 32'h508, 32'hC3);
        wr(32'hA00, 32'hFFFF_FF3C);
        rd_chk("R6 gpo 8 bits", 32'hA00, 32'h3C);

        // R8 two-wire registers
        wr(32'hB08, 32'hFFFF_FFFF);
        rd_chk("R8 oe 2 bits", 32'hB08, 32'h3);
        for (int p = 0; p < 4; p++) begin
            wr(32'hB10, 32'hA5A5_A5A4 | p);
            chk("R8 pins", {62'h0, twi_scl_o, twi_sda_o}, 64'(p));
            rd_chk("R8 out readback", 32'hB10, 32'hA5A5_A5A4 | p);
        end

        // R10 select gating
        rd_chk("R10 sel1 mirrors", 32'hA08, 32'hA5A5_A5A7);
        wr(32'hB18, 32'hFFFF_FFFE);
        rd_chk("R8 sel cleared", 32'hB18, 32'h0);
        rd_chk("R10 sel0 zero", 32'hA08, 32'h0);
        wr(32'hB18, 32'h3);
        rd_chk("R8 sel 1 bit", 32'hB18, 32'h1);
        rd_chk("R10 sel1 again", 32'hA08, 32'hA5A5_A5A7);

        // R9 live data input
        twi_sda_i = 1'b0;
        rd_chk("R9 sda low", 32'hB00, 32'h2);
        twi_sda_i = 1'b1;
        rd_chk("R9 sda high", 32'hB00, 32'h3);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule